// File: doc/BRIEF.md
# Configurable Serializer with Loopback Paths

This block turns parallel words into a serial bit stream for a line transmitter. It runs on one fast bit clock and produces its own word-rate strobe, `word_stb`, which marks the first bit slot of each word. A three-bit mode code selects 2:1, 4:1 or 8:1 serialization, so only the low 2, 4 or all 8 input bits are sent. Input bit 0 always leaves first. The selected ratio changes only at a word boundary, so a word is never cut short.

A two-bit phase code picks the bit slot, within the word period, where the parallel input is sampled. This lets the upstream logic place its data change anywhere in the word. A word sampled during one word period is sent during the next one.

Two loopback paths support test. When the active-low line loopback is asserted, the serial output carries an external serial input in place of the serializer output. When the active-low system loopback is asserted, a complementary output pair carries the serializer's own stream. When it is released, the pair rests at 0 and 1. One mode code is unused: it silences the transmitted stream and raises an error flag.

Top module: `lane_serializer`

## Requirements
- R1: The mode code `mode_sel` sets the bits per word: codes 000 and 100 give 2, codes 010 and 110 give 4, and codes 001, 101, 111 and 011 give 8. `word_stb` is high for one cycle at the start of each word, so consecutive strobes are exactly that many cycles apart.
- R2: The word sampled during one word period is sent during the next. Bit 0 is sent in the strobe cycle and bit k in the k-th cycle after it, using bits 0 to N-1 for ratio N.
- R3: The input is sampled at bit slot floor(p*N/4) of the word, where p is `phase_sel` read as an unsigned number 0 to 3 and slot 0 is the strobe cycle.
- R4: While the latched mode is code 011, `mode_error` is 1, the transmitted stream is constant 0 and words are 8 bits long. For every other code `mode_error` is 0.
- R5: A new mode code takes effect only at the next word boundary. `mode_error` changes only on a cycle where `word_stb` is high.
- R6: While `line_lb_n` is 0, `ser_out` equals `lb_data`.
- R7: While `sys_lb_n` is 0, `slb_p` carries the transmitted stream and `slb_n` its complement, independent of `line_lb_n`.
- R8: While `sys_lb_n` is 1, `slb_p` is 0 and `slb_n` is 1.
- R9: During and right after reset, `word_stb` is 1, the transmitted stream is 0, `mode_error` is 0 and the ratio is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | Serialization mode code |
| phase_sel | input | 2 | Input sampling slot select, in quarter words |
| par_data | input | W | Parallel input word, bit 0 sent first |
| line_lb_n | input | 1 | Line loopback enable, active low |
| lb_data | input | 1 | External serial data for line loopback |
| sys_lb_n | input | 1 | System loopback enable, active low |
| word_stb | output | 1 | Word start strobe (word-clock enable) |
| ser_out | output | 1 | Serial line output |
| slb_p | output | 1 | System loopback output, true |
| slb_n | output | 1 | System loopback output, complement |
| mode_error | output | 1 | Latched mode is the unused code |

## Verification
The hardest case to reach is a word whose sampled value depends on the phase code. When the parallel input is held for a whole word, every phase gives the same result. The bench therefore drives a fresh random value into `par_data` on every bit cycle. It tracks the bit slot from `word_stb` alone and queues the value present at the slot that the phase rule names, so a wrong sampling slot or a one-cycle skew shows up as a bit mismatch. The unused code and the mode changes are also exercised across word boundaries, and the strobe spacing is checked there.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
    typedef enum logic [1:0] {
        RATIO_2 = 2'd0,
        RATIO_4 = 2'd1,
        RATIO_8 = 2'd2
    } ratio_e;

    typedef struct packed {
        ratio_e ratio;
        logic   bad;
    } mode_t;

    // low two code bits pick the ratio, upper bit only rescues code 11
    function automatic mode_t decode_mode(input logic [2:0] code);
        mode_t m;
        m.bad = 1'b0;
        unique case (code[1:0])
            2'b00:   m.ratio = RATIO_2;
            2'b01:   m.ratio = RATIO_8;
            2'b10:   m.ratio = RATIO_4;
            default: begin
                m.ratio = RATIO_8;
                m.bad   = ~code[2];
            end
        endcase
        return m;
    endfunction

    function automatic int ratio_len(input ratio_e r, input int width);
        unique case (r)
            RATIO_2: return width / 4;
            RATIO_4: return width / 2;
            default: return width;
        endcase
    endfunction

    function automatic int sample_slot(input int n, input logic [1:0] p);
        return (int'(p) * n) / 4;
    endfunction
endpackage

// File: rtl/ser_word_timer.sv
`timescale 1ns/1ps
module ser_word_timer import ser_pkg::*; #(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic [1:0] phase_sel,
    output logic       word_stb,
    output logic       last_slot,
    output logic       capture,
    output logic       bad
);
    localparam int CNTW = $clog2(W) + 1;

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        ratio_e          ratio;
        logic            bad;
    } tstate_t;

    tstate_t st_d, st_q;
    logic [CNTW-1:0] len_m1;
    logic [CNTW-1:0] samp;
    mode_t           nxt_mode;

    always_comb begin
        len_m1   = CNTW'(ratio_len(st_q.ratio, W) - 1);
        samp     = CNTW'(sample_slot(ratio_len(st_q.ratio, W), phase_sel));
        nxt_mode = decode_mode(mode_sel);
        st_d     = st_q;
        if (st_q.cnt == len_m1) begin
            st_d.cnt   = '0;
            st_d.ratio = nxt_mode.ratio;
            st_d.bad   = nxt_mode.bad;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.ratio <= RATIO_8;
            st_q.bad   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_stb  = (st_q.cnt == '0);
    assign last_slot = (st_q.cnt == len_m1);
    assign capture   = (st_q.cnt == samp);
    assign bad       = st_q.bad;
endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] par_data,
    input  logic         capture,
    input  logic         last_slot,
    output logic         tx_bit
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] sreg;
    } sstate_t;

    sstate_t st_d, st_q;
    logic [W-1:0] cap_val;

    always_comb begin
        cap_val   = capture ? par_data : st_q.hold;
        st_d.hold = cap_val;
        st_d.sreg = last_slot ? cap_val : (st_q.sreg >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_bit = st_q.sreg[0];
endmodule

// File: rtl/ser_out_mux.sv
`timescale 1ns/1ps
module ser_out_mux (
    input  logic tx_bit,
    input  logic bad,
    input  logic line_lb_n,
    input  logic lb_data,
    input  logic sys_lb_n,
    output logic ser_out,
    output logic slb_p,
    output logic slb_n
);
    logic tx;

    always_comb begin
        tx      = tx_bit & ~bad;
        ser_out = line_lb_n ? tx : lb_data;
        slb_p   = sys_lb_n ? 1'b0 : tx;
        slb_n   = sys_lb_n ? 1'b1 : ~tx;
    end
endmodule

// File: rtl/lane_serializer.sv
`timescale 1ns/1ps
module lane_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_sel,
    input  logic [1:0]   phase_sel,
    input  logic [W-1:0] par_data,
    input  logic         line_lb_n,
    input  logic         lb_data,
    input  logic         sys_lb_n,
    output logic         word_stb,
    output logic         ser_out,
    output logic         slb_p,
    output logic         slb_n,
    output logic         mode_error
);
    logic last_slot;
    logic capture;
    logic bad;
    logic tx_bit;

    ser_word_timer #(.W(W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .phase_sel (phase_sel),
        .word_stb  (word_stb),
        .last_slot (last_slot),
        .capture   (capture),
        .bad       (bad)
    );

    ser_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_data  (par_data),
        .capture   (capture),
        .last_slot (last_slot),
        .tx_bit    (tx_bit)
    );

    ser_out_mux u_mux (
        .tx_bit    (tx_bit),
        .bad       (bad),
        .line_lb_n (line_lb_n),
        .lb_data   (lb_data),
        .sys_lb_n  (sys_lb_n),
        .ser_out   (ser_out),
        .slb_p     (slb_p),
        .slb_n     (slb_n)
    );

    assign mode_error = bad;
endmodule

// File: rtl/ser_checker.sv
`timescale 1ns/1ps
module ser_checker (
    input logic clk,
    input logic rst_n,
    input logic line_lb_n,
    input logic lb_data,
    input logic sys_lb_n,
    input logic word_stb,
    input logic ser_out,
    input logic slb_p,
    input logic slb_n,
    input logic mode_error
);
    a_r1_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    a_r4_error_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_error && line_lb_n) |-> !ser_out);

    a_r5_error_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_error) |-> word_stb);

    a_r6_line_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !line_lb_n |-> (ser_out == lb_data));

    a_r7_pair_opposite: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_lb_n |-> (slb_p != slb_n));

    a_r8_idle_pair: assert property (@(posedge clk) disable iff (!rst_n)
        sys_lb_n |-> (!slb_p && slb_n));
endmodule

bind lane_serializer ser_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_lb_n  (line_lb_n),
    .lb_data    (lb_data),
    .sys_lb_n   (sys_lb_n),
    .word_stb   (word_stb),
    .ser_out    (ser_out),
    .slb_p      (slb_p),
    .slb_n      (slb_n),
    .mode_error (mode_error)
);

// File: tb/lane_serializer_tb.sv
`timescale 1ns/1ps
module lane_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b111;
    logic [1:0] phase_sel = 2'b00;
    logic [7:0] par_data = 8'h00;
    logic       line_lb_n = 1'b1;
    logic       lb_data = 1'b0;
    logic       sys_lb_n = 1'b1;
    logic       word_stb, ser_out, slb_p, slb_n, mode_error;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lane_serializer #(.W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .phase_sel(phase_sel),
        .par_data(par_data), .line_lb_n(line_lb_n), .lb_data(lb_data),
        .sys_lb_n(sys_lb_n), .word_stb(word_stb), .ser_out(ser_out),
        .slb_p(slb_p), .slb_n(slb_n), .mode_error(mode_error)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // bench-side mode rules
    function automatic int exp_len(input logic [2:0] c);
        case (c[1:0])
            2'b00:   return 2;
            2'b10:   return 4;
            default: return 8;
        endcase
    endfunction

    // scoreboard state
    logic [7:0] exp_q[$];
    bit         chk_en = 0;
    int         wcount = 0;
    int         slot = 0;
    int         since = 0;
    int         cur_n = 8;
    bit         cur_bad = 0;
    bit         cur_valid = 0;
    bit         seen_stb = 0;
    logic [7:0] cur_exp = 8'h00;

    // monitor and data driver, both at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (word_stb) begin
                if (seen_stb)
                    check(since == cur_n, "R1 R5 word period", since, cur_n);
                seen_stb = 1;
                since = 0;
                slot = 0;
                cur_n = exp_len(mode_sel);
                cur_bad = (mode_sel == 3'b011);
                if (chk_en && exp_q.size() > 0) begin
                    cur_exp = exp_q.pop_front();
                    cur_valid = 1;
                end else begin
                    cur_valid = 0;
                    if (!chk_en) exp_q.delete();
                end
                wcount++;
            end else begin
                slot++;
            end
            since++;

            check(mode_error == cur_bad, "R4 mode_error", int'(mode_error), int'(cur_bad));

            if (chk_en && cur_valid && slot < cur_n) begin
                logic obs, expb;
                obs  = line_lb_n ? ser_out : slb_p;
                expb = cur_bad ? 1'b0 : cur_exp[slot];
                check(obs == expb, cur_bad ? "R4 silent stream" : "R2 R3 serial bit",
                      int'(obs), int'(expb));
            end

            if (!line_lb_n)
                check(ser_out == lb_data, "R6 line loopback", int'(ser_out), int'(lb_data));
            if (sys_lb_n) begin
                check(!slb_p && slb_n, "R8 idle pair", int'({slb_p, slb_n}), 1);
            end else begin
                check(slb_n == ~slb_p, "R7 pair complement", int'({slb_p, slb_n}), int'({slb_p, ~slb_p}));
                if (line_lb_n)
                    check(slb_p == ser_out, "R7 loop carries stream", int'(slb_p), int'(ser_out));
            end

            par_data = 8'($urandom);
            lb_data  = 1'($urandom);
            if (chk_en && slot == (int'(phase_sel) * cur_n) / 4)
                exp_q.push_back(par_data);
        end
    end

    task automatic wait_words(input int k);
        int t;
        t = wcount + k;
        while (wcount < t) @(negedge clk);
        #1;
    endtask

    task automatic run_cfg(input logic [2:0] code, input logic [1:0] ph,
                           input logic llb, input logic slb, input int nw);
        @(negedge clk);
        #1;
        chk_en = 0;
        mode_sel = code;
        phase_sel = ph;
        line_lb_n = llb;
        sys_lb_n = slb;
        wait_words(3);
        chk_en = 1;
        wait_words(nw);
        chk_en = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(word_stb == 1'b1, "R9 reset strobe", int'(word_stb), 1);
        check(ser_out == 1'b0, "R9 reset stream", int'(ser_out), 0);
        check(mode_error == 1'b0, "R9 reset error flag", int'(mode_error), 0);
        check(!slb_p && slb_n, "R9 R8 reset pair", int'({slb_p, slb_n}), 1);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #0;
        check(word_stb == 1'b0 && ser_out == 1'b0, "R9 first bits after reset",
              int'({word_stb, ser_out}), 0);

        // R1 R2 R3: every ratio with every phase
        for (int p = 0; p < 4; p++) run_cfg(3'b111, 2'(p), 1'b1, 1'b1, 6);
        for (int p = 0; p < 4; p++) run_cfg(3'b000, 2'(p), 1'b1, 1'b1, 8);
        for (int p = 0; p < 4; p++) run_cfg(3'b010, 2'(p), 1'b1, 1'b1, 6);
        run_cfg(3'b100, 2'd3, 1'b1, 1'b1, 8);
        run_cfg(3'b110, 2'd2, 1'b1, 1'b1, 6);
        run_cfg(3'b101, 2'd1, 1'b1, 1'b1, 6);
        run_cfg(3'b001, 2'd3, 1'b1, 1'b1, 6);
        // R4: unused code, then recovery
        run_cfg(3'b011, 2'd1, 1'b1, 1'b1, 6);
        run_cfg(3'b000, 2'd1, 1'b1, 1'b1, 8);
        // R7: system loopback alone and under line loopback (R6)
        run_cfg(3'b010, 2'd3, 1'b1, 1'b0, 8);
        run_cfg(3'b111, 2'd2, 1'b0, 1'b0, 6);
        run_cfg(3'b000, 2'd0, 1'b0, 1'b0, 8);
        run_cfg(3'b011, 2'd0, 1'b1, 1'b0, 4);
        // R5: rapid mode changes, strobe spacing checked throughout
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            #1 mode_sel = 3'(k * 3);
            repeat (3) @(negedge clk);
        end
        run_cfg(3'b111, 2'd0, 1'b1, 1'b1, 4);
        finish_run();
    end
endmodule